// File: doc/BRIEF.md
# Byte-Lane Bank Access Splitter

This block connects a simple load/store request port to a 16-bit memory bus that is built from two 8-bit banks. The even bank holds bytes at even addresses and sits on data lanes 7:0. It is selected when address bit 0 is low. The odd bank holds bytes at odd addresses and sits on lanes 15:8. It is selected when the active-low high-byte enable is low. For each request, the block picks the bank enables and puts the write bytes on the right lanes. It also gathers read bytes back into a right-justified result.

A word access at an odd address cannot be served in one bus transaction. The block splits it into two single-byte transactions, issued in a fixed order. The first transaction moves the low byte through the odd bank at the given address. The second moves the high byte through the even bank at the next address, which wraps modulo 2^20. Each transaction goes through a request/acknowledge handshake to a downstream cycle engine. When the last transaction has been acknowledged, the block pulses `done_o` and presents the 16-bit result.

Top module: `bank_split_ctrl`

## Requirements
- R1: After reset, `busy_o`, `bus_req_o` and `done_o` are all 0.
- R2: A byte access at an even address makes one transaction with `bus_bhe_n_o`=1 and `bus_addr_o[0]`=0. A read returns lanes 7:0 in result bits 7:0, with bits 15:8 zero. In every transaction the two banks are never both disabled.
- R3: A byte access at an odd address makes one transaction with `bus_bhe_n_o`=0 and `bus_addr_o[0]`=1. A read takes lanes 15:8 and returns them in result bits 7:0, with bits 15:8 zero. A byte write drives the byte on both lanes (`{b,b}`).
- R4: A word access at an even address makes one transaction with `bus_bhe_n_o`=0 and `bus_addr_o[0]`=0. All 16 lanes carry the word unchanged in both directions.
- R5: A word access at an odd address A makes two transactions in this order.
  - First, address A with `bus_bhe_n_o`=0, carrying the word's low byte on lanes 15:8.
  - Second, address A+1 with `bus_bhe_n_o`=1, carrying the high byte on lanes 7:0.
  - A read result is {byte from second transaction lanes 7:0, byte from first transaction lanes 15:8}.
- R6: The second address of a split access is A+1 modulo 2^20, so 0xFFFFF is followed by 0x00000.
- R7: `done_o` is a one-cycle pulse. It rises in the cycle after the acknowledge of the final transaction, and never after the first half of a split access. `rdata_o` is valid while `done_o` is high.
- R8: A start is accepted only while `busy_o` is 0. `busy_o` rises in the cycle after an accepted start and stays high until the access completes. A start seen while busy is ignored and produces no transaction.
- R9: `bus_req_o` stays high, with address, enable, direction and write lanes stable, until `bus_ack_i` is seen. The acknowledge cycle ends the transaction, and read lanes are sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a new access |
| write_i | input | 1 | 1 = store, 0 = load |
| word_i | input | 1 | 1 = 16-bit word, 0 = byte |
| addr_i | input | 20 | Byte address |
| wdata_i | input | 16 | Store data, a byte in bits 7:0 |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Load result, right-justified |
| bus_req_o | output | 1 | Transaction request to cycle engine |
| bus_ack_i | input | 1 | Transaction acknowledge |
| bus_addr_o | output | 20 | Transaction byte address, bit 0 selects even bank when low |
| bus_bhe_n_o | output | 1 | Active-low odd bank enable |
| bus_we_o | output | 1 | Transaction direction, 1 = write |
| bus_wdata_o | output | 16 | Write lanes |
| bus_rdata_i | input | 16 | Read lanes, valid in the acknowledge cycle |

## Verification
The assertions assume that the cycle engine raises `bus_ack_i` only while `bus_req_o` is high, and for a single cycle per transaction. The bench's responder follows this rule: it answers once per request after a programmable latency, then drops the acknowledge on the next cycle. The assertions also assume that `start_i` is a short pulse. The bench drives it only from its tasks, holding it for one cycle, except in the test that deliberately raises start while the block is busy.

// File: rtl/bank_split_pkg.sv
package bank_split_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_XFER = 1'b1
    } phase_t;
endpackage

// File: rtl/lane_plan.sv
// Per-transaction bank enable and write-lane steering.
module lane_plan #(
    parameter int BYTE_W = 8
) (
    input  logic                  word_i,
    input  logic                  second_i,
    input  logic                  addr0_i,
    input  logic [2*BYTE_W-1:0]   wdata_i,
    output logic                  full_o,
    output logic                  bhe_n_o,
    output logic [2*BYTE_W-1:0]   lanes_o
);
    logic [BYTE_W-1:0] pick;

    always_comb begin
        full_o  = word_i && !second_i && !addr0_i;
        bhe_n_o = !(full_o || addr0_i);
        pick    = second_i ? wdata_i[2*BYTE_W-1:BYTE_W] : wdata_i[BYTE_W-1:0];
        lanes_o = full_o ? wdata_i : {pick, pick};
    end
endmodule

// File: rtl/read_merge.sv
// Gathers read lanes into a right-justified result.
module read_merge #(
    parameter int BYTE_W = 8
) (
    input  logic                  full_i,
    input  logic                  second_i,
    input  logic                  addr0_i,
    input  logic [2*BYTE_W-1:0]   lanes_i,
    input  logic [BYTE_W-1:0]     held_i,
    output logic [BYTE_W-1:0]     byte_o,
    output logic [2*BYTE_W-1:0]   result_o
);
    always_comb begin
        byte_o = addr0_i ? lanes_i[2*BYTE_W-1:BYTE_W] : lanes_i[BYTE_W-1:0];
        if (full_i)
            result_o = lanes_i;
        else if (second_i)
            result_o = {byte_o, held_i};
        else
            result_o = {{BYTE_W{1'b0}}, byte_o};
    end
endmodule

// File: rtl/bank_split_ctrl.sv
module bank_split_ctrl #(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  write_i,
    input  logic                  word_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [2*BYTE_W-1:0]   wdata_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [2*BYTE_W-1:0]   rdata_o,
    output logic                  bus_req_o,
    input  logic                  bus_ack_i,
    output logic [ADDR_W-1:0]     bus_addr_o,
    output logic                  bus_bhe_n_o,
    output logic                  bus_we_o,
    output logic [2*BYTE_W-1:0]   bus_wdata_o,
    input  logic [2*BYTE_W-1:0]   bus_rdata_i
);
    import bank_split_pkg::*;

    localparam int DATA_W = 2 * BYTE_W;

    typedef struct packed {
        phase_t              phase;
        logic                second;
        logic                we;
        logic                word;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [BYTE_W-1:0]   held;
        logic                done;
        logic [DATA_W-1:0]   rdata;
    } state_t;

    state_t st_q, st_d;

    logic                full;
    logic                bhe_n;
    logic [DATA_W-1:0]   lanes_w;
    logic [BYTE_W-1:0]   rd_byte;
    logic [DATA_W-1:0]   rd_result;
    logic                needs_split;

    lane_plan #(.BYTE_W(BYTE_W)) u_plan (
        .word_i   (st_q.word),
        .second_i (st_q.second),
        .addr0_i  (st_q.addr[0]),
        .wdata_i  (st_q.wdata),
        .full_o   (full),
        .bhe_n_o  (bhe_n),
        .lanes_o  (lanes_w)
    );

    read_merge #(.BYTE_W(BYTE_W)) u_merge (
        .full_i   (full),
        .second_i (st_q.second),
        .addr0_i  (st_q.addr[0]),
        .lanes_i  (bus_rdata_i),
        .held_i   (st_q.held),
        .byte_o   (rd_byte),
        .result_o (rd_result)
    );

    assign needs_split = st_q.word && st_q.addr[0] && !st_q.second;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase  = PH_XFER;
                    st_d.second = 1'b0;
                    st_d.we     = write_i;
                    st_d.word   = word_i;
                    st_d.addr   = addr_i;
                    st_d.wdata  = wdata_i;
                end
            end
            PH_XFER: begin
                if (bus_ack_i) begin
                    if (needs_split) begin
                        st_d.second = 1'b1;
                        st_d.held   = rd_byte;
                        st_d.addr   = st_q.addr + ADDR_W'(1);
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                        st_d.rdata = rd_result;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = (st_q.phase == PH_XFER);
    assign done_o      = st_q.done;
    assign rdata_o     = st_q.rdata;
    assign bus_req_o   = (st_q.phase == PH_XFER);
    assign bus_addr_o  = st_q.addr;
    assign bus_bhe_n_o = bhe_n;
    assign bus_we_o    = st_q.we;
    assign bus_wdata_o = lanes_w;
endmodule

// File: rtl/bank_split_chk.sv
module bank_split_chk #(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic                  bus_req_o,
    input logic                  bus_ack_i,
    input logic [ADDR_W-1:0]     bus_addr_o,
    input logic                  bus_bhe_n_o,
    input logic                  bus_we_o,
    input logic [2*BYTE_W-1:0]   bus_wdata_o
);
    assert_bank_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> !(bus_bhe_n_o && bus_addr_o[0]));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(bus_req_o && bus_ack_i));

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_bhe_n_o)
                                       && $stable(bus_we_o) && $stable(bus_wdata_o)));
endmodule

bind bank_split_ctrl bank_split_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .bus_req_o   (bus_req_o),
    .bus_ack_i   (bus_ack_i),
    .bus_addr_o  (bus_addr_o),
    .bus_bhe_n_o (bus_bhe_n_o),
    .bus_we_o    (bus_we_o),
    .bus_wdata_o (bus_wdata_o)
);

// File: tb/bank_split_ctrl_tb.sv
module bank_split_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        write_i = 1'b0;
    logic        word_i = 1'b0;
    logic [19:0] addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic        busy_o, done_o, bus_req_o, bus_bhe_n_o, bus_we_o;
    logic [15:0] rdata_o, bus_wdata_o;
    logic [19:0] bus_addr_o;
    logic        bus_ack_i = 1'b0;
    logic [15:0] bus_rdata_i = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_split_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i), .word_i(word_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o),
        .rdata_o(rdata_o), .bus_req_o(bus_req_o), .bus_ack_i(bus_ack_i),
        .bus_addr_o(bus_addr_o), .bus_bhe_n_o(bus_bhe_n_o), .bus_we_o(bus_we_o),
        .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i)
    );

    int n_run = 0;
    int n_fail = 0;

    // bus responder model: 32-byte memory, trace of transactions
    logic [7:0]  mem [32];
    int          lat = 0;
    int          wcnt = 0;
    int          ntx = 0;
    logic [19:0] t_addr [4];
    logic        t_bhe  [4];
    logic [15:0] t_wd   [4];
    int          ndone = 0;
    logic [15:0] got_rdata;

    always @(negedge clk) begin
        if (done_o) begin
            ndone = ndone + 1;
            got_rdata = rdata_o;
        end
        if (bus_ack_i) begin
            bus_ack_i = 1'b0;
            wcnt = 0;
        end else if (bus_req_o) begin
            if (wcnt >= lat) begin
                if (ntx < 4) begin
                    t_addr[ntx] = bus_addr_o;
                    t_bhe[ntx]  = bus_bhe_n_o;
                    t_wd[ntx]   = bus_wdata_o;
                end
                ntx = ntx + 1;
                if (bus_we_o) begin
                    if (!bus_addr_o[0]) mem[{bus_addr_o[4:1], 1'b0}] = bus_wdata_o[7:0];
                    if (!bus_bhe_n_o)   mem[{bus_addr_o[4:1], 1'b1}] = bus_wdata_o[15:8];
                end
                bus_rdata_i = {mem[{bus_addr_o[4:1], 1'b1}], mem[{bus_addr_o[4:1], 1'b0}]};
                bus_ack_i = 1'b1;
            end else begin
                wcnt = wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run = n_run + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input bit wd, input logic [19:0] a,
                          input logic [15:0] d, input int latency);
        int start_done;
        lat = latency;
        ntx = 0;
        start_done = ndone;
        @(negedge clk);
        start_i = 1'b1; write_i = we; word_i = wd; addr_i = a; wdata_i = d;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 200 && ndone == start_done; i++) @(negedge clk);
        @(negedge clk);
        chk(ndone == start_done + 1, "R7", "done pulses", ndone - start_done, 1);
    endtask

    task automatic t_reset();
        chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        chk(bus_req_o == 1'b0, "R1", "req after reset", bus_req_o, 0);
        chk(done_o == 1'b0, "R1", "done after reset", done_o, 0);
    endtask

    task automatic t_even_byte();
        access(1'b0, 1'b0, 20'h00004, 16'h0, 0);
        chk(ntx == 1, "R2", "txn count", ntx, 1);
        chk(t_bhe[0] == 1'b1 && t_addr[0][0] == 1'b0, "R2", "enables", {t_bhe[0], t_addr[0][0]}, 2'b10);
        chk(got_rdata == {8'h00, mem[4]}, "R2", "read even byte", got_rdata, {8'h00, mem[4]});
    endtask

    task automatic t_odd_byte();
        access(1'b0, 1'b0, 20'h00007, 16'h0, 2);
        chk(ntx == 1, "R3", "txn count", ntx, 1);
        chk(t_bhe[0] == 1'b0 && t_addr[0][0] == 1'b1, "R3", "enables", {t_bhe[0], t_addr[0][0]}, 2'b01);
        chk(got_rdata == {8'h00, mem[7]}, "R3", "read odd byte", got_rdata, {8'h00, mem[7]});
        access(1'b1, 1'b0, 20'h00009, 16'h77C3, 1);
        chk(t_wd[0] == 16'hC3C3, "R3", "write lanes", t_wd[0], 16'hC3C3);
        chk(mem[9] == 8'hC3 && mem[8] != 8'hC3, "R3", "odd bank only", {mem[9], mem[8]}, 8'hC3);
    endtask

    task automatic t_even_word();
        access(1'b1, 1'b1, 20'h0000A, 16'hBEEF, 0);
        chk(ntx == 1 && t_bhe[0] == 1'b0 && t_addr[0][0] == 1'b0, "R4", "word enables",
            {ntx[3:0], t_bhe[0]}, 8'h10);
        chk(t_wd[0] == 16'hBEEF, "R4", "write lanes", t_wd[0], 16'hBEEF);
        access(1'b0, 1'b1, 20'h0000A, 16'h0, 3);
        chk(got_rdata == 16'hBEEF, "R4", "read word", got_rdata, 16'hBEEF);
    endtask

    task automatic t_odd_word();
        access(1'b1, 1'b1, 20'h00011, 16'h5AA5, 1);
        chk(ntx == 2, "R5", "split txn count", ntx, 2);
        chk(t_addr[0] == 20'h00011 && t_bhe[0] == 1'b0, "R5", "first txn", t_addr[0], 20'h00011);
        chk(t_wd[0][15:8] == 8'hA5, "R5", "first lanes", t_wd[0], 16'hA5A5);
        chk(t_addr[1] == 20'h00012 && t_bhe[1] == 1'b1, "R5", "second txn", t_addr[1], 20'h00012);
        chk(t_wd[1][7:0] == 8'h5A, "R5", "second lanes", t_wd[1], 16'h5A5A);
        access(1'b0, 1'b1, 20'h00011, 16'h0, 0);
        chk(got_rdata == 16'h5AA5, "R5", "split read", got_rdata, 16'h5AA5);
    endtask

    task automatic t_wrap();
        access(1'b0, 1'b1, 20'hFFFFF, 16'h0, 1);
        chk(ntx == 2 && t_addr[1] == 20'h00000, "R6", "wrap address", t_addr[1], 20'h00000);
        chk(got_rdata == {mem[0], mem[31]}, "R6", "wrap read", got_rdata, {mem[0], mem[31]});
    endtask

    task automatic t_busy();
        int d0;
        lat = 4;
        ntx = 0;
        d0 = ndone;
        @(negedge clk);
        start_i = 1'b1; write_i = 1'b0; word_i = 1'b1; addr_i = 20'h00003;
        @(negedge clk);
        chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
        addr_i = 20'h00014; word_i = 1'b0;   // start still high while busy
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 200 && ndone == d0; i++) @(negedge clk);
        chk(ndone == d0 + 1, "R7", "single done for split", ndone - d0, 1);
        chk(got_rdata == {mem[4], mem[3]}, "R8", "original access served", got_rdata, {mem[4], mem[3]});
        for (int i = 0; i < 6; i++) @(negedge clk);
        chk(ntx == 2 && bus_req_o == 1'b0, "R8", "ignored start has no txn", ntx, 2);
        chk(busy_o == 1'b0, "R8", "idle after done", busy_o, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_even_byte();
        t_odd_byte();
        t_even_word();
        t_odd_word();
        t_wrap();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_run = n_run + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule